// File: doc/BRIEF.md
# Serial SAR Conversion Sequencer

This block is the digital half of a serially addressed 8-bit successive-approximation converter with a 4-channel or 8-channel analog front end. The host pulls the active-low select low and clocks in a start bit followed by a short assignment word. The block decodes the word into one-hot positive and negative switch selects for an external analog multiplexer. After one settling period it runs an 8-step binary search against a single comparator bit and drives the trial code to an external DAC. The result goes out on a serial line while the search runs, most significant bit first. A stored copy is then sent back least significant bit first.

The serial output and the status line are modelled as tri-state pins, each a data bit with an enable. Inputs are sampled on the rising clock edge. The serial data, its enable and the status bit change on the falling edge, so the host can sample them on the next rising edge. The state machine has seven states. IDLE waits for the start bit. ADDR shifts in the assignment word. SETTLE drives the leading low while the MSB trial sits on the DAC. CONV decides the remaining bits. HOLD is used on the 8-channel build only and keeps the LSB on the line. REPLAY sends the LSB-first copy. DONE releases the line. The transitions are:

- IDLE to ADDR on a high data bit.
- ADDR to SETTLE after the last word bit.
- SETTLE to CONV unconditionally.
- CONV to REPLAY on the 4-channel build, or CONV to HOLD on the 8-channel build, once bit 0 is decided.
- HOLD to REPLAY when the hold input is low.
- REPLAY to DONE after bit 7.

Chip select high returns the machine to IDLE from any state.

Top module: `sar_serial_seq`

## Requirements
- R1: While `cs_n` is high, all state is cleared asynchronously: `dout_oe`, `busy_oe` and `busy` are 0, and `pos_sel` and `neg_sel` are all zero. Raising `cs_n` in the middle of a conversion aborts it at once.
- R2: After `cs_n` falls, low bits on `din` are ignored. The first high bit sampled on a rising edge is the start bit.
- R3: The assignment word follows the start bit and is sent first bit first. On the 8-channel build it is 4 bits: single/differential (1 = single-ended), odd/sign, select1, select0. On the 4-channel build it is 3 bits: single/differential, odd/sign, select1. The channel index is {select1, select0, odd} on the 8-channel build and {select1, odd} on the 4-channel build.
- R4: In single-ended mode, `pos_sel` is one-hot at the channel index and `neg_sel` has only bit NUM_CH set. That bit is ground on the 4-channel build and the common terminal on the 8-channel build. The selects are driven only in SETTLE and CONV and are zero in every other state.
- R5: In differential mode, `pos_sel` selects the channel index and `neg_sel` selects its pair partner (index XOR 1). Only adjacent pairs 0/1, 2/3, 4/5 and 6/7 are formed.
- R6: On the falling edge after the last word bit is sampled, `dout_oe` becomes 1, `dout` is 0 and `busy` is 1. `dac_code` holds 0x80 during this settling period.
- R7: Each search step keeps the trial bit when `cmp_ge` is 1 (input at or above `dac_code`) and clears it otherwise. At the end, `dac_code` equals the result, which is min(max(Vpos − Vneg, 0), 255). A comparator that always reads 0 gives 0x00.
- R8: On the 8 falling edges after the settling period, `dout` shows result bits 7 down to 0 in turn.
- R9: `busy` stays high for exactly 8 clock periods: the settling period and the first seven bits. It falls on the edge where bit 0 appears. `busy` high implies `dout_oe` high.
- R10: Once the start bit has been taken, `din` has no effect until `cs_n` rises. Toggling it during the conversion and the replay leaves the result stream unchanged.
- R11: On the 4-channel build, result bits 1 to 7 follow bit 0 on the next 7 falling edges with no host action.
- R12: On the 8-channel build, while `lsb_hold` is high, bit 0 stays on `dout`. One period after `lsb_hold` is low at a rising edge, bits 1 to 7 are shifted out.
- R13: After bit 7 of the LSB-first copy, `dout_oe` and `busy` are 0 until `cs_n` rises. Further start bits without a chip-select cycle start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select, asynchronous clear when high |
| din | input | 1 | Serial start bit and assignment word |
| lsb_hold | input | 1 | 8-channel build: high keeps the LSB on the line |
| cmp_ge | input | 1 | Comparator: analog input at or above `dac_code` |
| dac_code | output | RES | Trial code for the external DAC |
| pos_sel | output | NUM_CH | One-hot positive switch select |
| neg_sel | output | NUM_CH+1 | One-hot negative select, top bit is ground or common |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Drive enable for `dout` |
| busy | output | 1 | Conversion in progress |
| busy_oe | output | 1 | Drive enable for `busy` |

## Verification
The bench builds two instances side by side, one with NUM_CH=8 and one with NUM_CH=4, both at RES=8. Together they reach both word lengths, the hold path and the automatic replay. Every assignment word of each build is swept: 16 on the 8-channel build and 8 on the 4-channel build. Each word gets its own analog voltages, and the bench computes the expected selects and codes arithmetically, including negative and over-range differences that clamp to 0x00 and 0xFF. Hold lengths of zero to two periods, `din` noise during the conversion, retried start bits after completion, and an abort in the middle of a conversion cover the ordering corner cases.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SETTLE,
        ST_CONV,
        ST_HOLD,
        ST_REPLAY,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/sarseq_chan_decode.sv
module sarseq_chan_decode #(
    parameter int NUM_CH = 8,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic              en,
    input  logic              single,
    input  logic [CH_W-1:0]   ch,
    output logic [NUM_CH-1:0] pos,
    output logic [NUM_CH:0]   neg
);
    localparam logic [CH_W-1:0] PAIR_FLIP = CH_W'(1);

    always_comb begin
        pos = '0;
        neg = '0;
        if (en) begin
            pos[ch] = 1'b1;
            if (single) begin
                neg[NUM_CH] = 1'b1;
            end else begin
                neg[ch ^ PAIR_FLIP] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sarseq_sar_core.sv
module sarseq_sar_core #(
    parameter int RES = 8
) (
    input  logic           clk,
    input  logic           cs_n,
    input  logic           load,
    input  logic           step,
    input  logic           cmp_ge,
    output logic [RES-1:0] acc,
    output logic [RES-1:0] trial,
    output logic           last_bit,
    output logic           final_step
);
    localparam logic [RES-1:0] TOP_TRIAL = {1'b1, {(RES-1){1'b0}}};

    always_ff @(posedge clk or posedge cs_n) begin
        if (cs_n) begin
            acc      <= '0;
            trial    <= '0;
            last_bit <= 1'b0;
        end else if (load) begin
            acc      <= '0;
            trial    <= TOP_TRIAL;
            last_bit <= 1'b0;
        end else if (step) begin
            if (cmp_ge) begin
                acc <= acc | trial;
            end
            last_bit <= cmp_ge;
            trial    <= trial >> 1;
        end
    end

    assign final_step = trial[0];

    assert_trial_onehot_R7: assert property (@(posedge clk) disable iff (cs_n)
        step |-> ($countones(trial) == 1));

    assert_keep_bit_R7: assert property (@(posedge clk) disable iff (cs_n)
        (step && cmp_ge) |=> ((acc & $past(trial)) != '0));
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
    import sarseq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int RES    = 8
) (
    input  logic              clk,
    input  logic              cs_n,
    input  logic              din,
    input  logic              lsb_hold,
    input  logic              cmp_ge,
    output logic [RES-1:0]    dac_code,
    output logic [NUM_CH-1:0] pos_sel,
    output logic [NUM_CH:0]   neg_sel,
    output logic              dout,
    output logic              dout_oe,
    output logic              busy,
    output logic              busy_oe
);
    localparam int WORD_W = (NUM_CH == 8) ? 4 : 3;
    localparam int CNT_W  = $clog2(WORD_W);
    localparam int IDX_W  = $clog2(RES);
    localparam int CH_W   = $clog2(NUM_CH);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(RES - 1);
    localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

    seq_state_t state, state_nx;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [RES-1:0]    acc, trial;
    logic              last_bit, final_step;
    logic              load, step, sel_en, single;
    logic [CH_W-1:0]   ch;
    logic              dout_nx, oe_nx, busy_nx;

    assign load   = (state == ST_ADDR) && (cnt == CNT_LAST);
    assign step   = (state == ST_SETTLE) || (state == ST_CONV);
    assign sel_en = step;
    assign single = word[WORD_W-1];

    generate
        if (NUM_CH == 8) begin : g_eight
            assign ch = {word[1], word[0], word[2]};
        end else begin : g_four
            assign ch = {word[0], word[1]};
        end
    endgenerate

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (din) state_nx = ST_ADDR;
            ST_ADDR:   if (cnt == CNT_LAST) state_nx = ST_SETTLE;
            ST_SETTLE: state_nx = ST_CONV;
            ST_CONV:   if (final_step) state_nx = (NUM_CH == 8) ? ST_HOLD : ST_REPLAY;
            ST_HOLD:   if (!lsb_hold) state_nx = ST_REPLAY;
            ST_REPLAY: if (idx == IDX_LAST) state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_DONE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge cs_n) begin
        if (cs_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or posedge cs_n) begin
        if (cs_n) begin
            word <= '0;
            cnt  <= '0;
            idx  <= '0;
        end else begin
            unique case (state)
                ST_ADDR: begin
                    word <= {word[WORD_W-2:0], din};
                    cnt  <= cnt + 1'b1;
                end
                ST_HOLD:   if (!lsb_hold) idx <= IDX_ONE;
                ST_REPLAY: if (idx != IDX_LAST) idx <= idx + 1'b1;
                default: ;
            endcase
        end
    end

    sarseq_sar_core #(.RES(RES)) sar_i (
        .clk(clk), .cs_n(cs_n), .load(load), .step(step), .cmp_ge(cmp_ge),
        .acc(acc), .trial(trial), .last_bit(last_bit), .final_step(final_step)
    );

    sarseq_chan_decode #(.NUM_CH(NUM_CH)) dec_i (
        .en(sel_en), .single(single), .ch(ch), .pos(pos_sel), .neg(neg_sel)
    );

    assign dac_code = acc | trial;
    assign busy_oe  = ~cs_n;

    always_comb begin
        dout_nx = 1'b0;
        oe_nx   = 1'b0;
        busy_nx = 1'b0;
        unique case (state)
            ST_SETTLE: begin oe_nx = 1'b1; busy_nx = 1'b1; end
            ST_CONV:   begin dout_nx = last_bit; oe_nx = 1'b1; busy_nx = 1'b1; end
            ST_HOLD, ST_REPLAY: begin dout_nx = acc[idx]; oe_nx = 1'b1; end
            default: ;
        endcase
    end

    always_ff @(negedge clk or posedge cs_n) begin
        if (cs_n) begin
            dout    <= 1'b0;
            dout_oe <= 1'b0;
            busy    <= 1'b0;
        end else begin
            dout    <= dout_nx;
            dout_oe <= oe_nx;
            busy    <= busy_nx;
        end
    end

    assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (cs_n)
        $onehot0(pos_sel) && $onehot0(neg_sel) && ((|pos_sel) == (|neg_sel)));

    assert_pair_adjacent_R5: assert property (@(posedge clk) disable iff (cs_n)
        ((|pos_sel) && !neg_sel[NUM_CH]) |->
        ((((pos_sel << 1) | (pos_sel >> 1)) & neg_sel[NUM_CH-1:0]) != '0));

    assert_busy_drives_R9: assert property (@(posedge clk) disable iff (cs_n)
        busy |-> dout_oe);

    assert_din_ignored_R10: assert property (@(posedge clk) disable iff (cs_n)
        (state == ST_CONV) |=> $stable(word));

    assert_done_quiet_R13: assert property (@(posedge clk) disable iff (cs_n)
        ((state == ST_DONE) && ($past(state) == ST_DONE)) |-> (!dout_oe && !busy));
endmodule

// File: tb/sar_serial_seq_tb_top.sv
module sar_serial_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic cs8_n, cs4_n, din, lsb_hold, cmp8, cmp4;
    logic [7:0] dac8, dac4, pos8;
    logic [8:0] neg8;
    logic [3:0] pos4;
    logic [4:0] neg4;
    logic dout8, oe8, busy8, boe8, dout4, oe4, busy4, boe4;
    int ain8 [0:8];
    int ain4 [0:4];
    int total = 0, bad = 0;
    int p8, n8, p4, n4;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_serial_seq #(.NUM_CH(8), .RES(8)) dut_i (
        .clk(clk), .cs_n(cs8_n), .din(din), .lsb_hold(lsb_hold), .cmp_ge(cmp8),
        .dac_code(dac8), .pos_sel(pos8), .neg_sel(neg8),
        .dout(dout8), .dout_oe(oe8), .busy(busy8), .busy_oe(boe8));

    sar_serial_seq #(.NUM_CH(4), .RES(8)) dut4_i (
        .clk(clk), .cs_n(cs4_n), .din(din), .lsb_hold(lsb_hold), .cmp_ge(cmp4),
        .dac_code(dac4), .pos_sel(pos4), .neg_sel(neg4),
        .dout(dout4), .dout_oe(oe4), .busy(busy4), .busy_oe(boe4));

    // analog model: comparator from the selected terminals
    always_comb begin
        p8 = 0; n8 = 0;
        for (int i = 0; i < 8; i++) begin
            if (pos8[i]) p8 = ain8[i];
            if (neg8[i]) n8 = ain8[i];
        end
        if (neg8[8]) n8 = ain8[8];
        cmp8 = (p8 - n8) >= int'(dac8);
        p4 = 0; n4 = 0;
        for (int i = 0; i < 4; i++) begin
            if (pos4[i]) p4 = ain4[i];
            if (neg4[i]) n4 = ain4[i];
        end
        if (neg4[4]) n4 = ain4[4];
        cmp4 = (p4 - n4) >= int'(dac4);
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic get(input bit v8, output int d, output int oe, output int bz,
                       output int boe, output int dac, output int pos, output int neg);
        if (v8) begin
            d = dout8; oe = oe8; bz = busy8; boe = boe8; dac = dac8; pos = pos8; neg = neg8;
        end else begin
            d = dout4; oe = oe4; bz = busy4; boe = boe4; dac = dac4; pos = pos4; neg = neg4;
        end
    endtask

    task automatic set_cs(input bit v8, input bit val);
        if (v8) cs8_n = val; else cs4_n = val;
    endtask

    task automatic check_idle(input bit v8, input string tag);
        int d, oe, bz, boe, dac, pos, neg;
        get(v8, d, oe, bz, boe, dac, pos, neg);
        chk({tag, " R1 dout_oe"}, oe, 0);
        chk({tag, " R1 busy_oe"}, boe, 0);
        chk({tag, " R1 busy"}, bz, 0);
        chk({tag, " R1 selects"}, pos | neg, 0);
    endtask

    task automatic conv(input bit v8, input int w, input int hold_n, input bit noise);
        int d, oe, bz, boe, dac, pos, neg;
        int nch, kb, sgl, ch, ep, en, diff, code;
        nch = v8 ? 8 : 4;
        kb  = v8 ? 4 : 3;
        sgl = v8 ? w[3] : w[2];
        ch  = v8 ? {w[1], w[0], w[2]} : {w[0], w[1]};
        ep  = 1 << ch;
        en  = sgl ? (1 << nch) : (1 << (ch ^ 1));
        if (v8) diff = ain8[ch] - (sgl ? ain8[8] : ain8[ch ^ 1]);
        else    diff = ain4[ch] - (sgl ? ain4[4] : ain4[ch ^ 1]);
        code = diff < 0 ? 0 : (diff > 255 ? 255 : diff);

        check_idle(v8, "pre");
        din = 1'b0; lsb_hold = (hold_n > 0);
        set_cs(v8, 1'b0);
        tick(); tick();
        get(v8, d, oe, bz, boe, dac, pos, neg);
        chk("R2 zeros before start", oe | bz, 0);
        chk("R1 busy_oe driven", boe, 1);
        din = 1'b1; tick();
        for (int b = kb - 1; b >= 0; b--) begin
            din = w[b]; tick();
        end
        get(v8, d, oe, bz, boe, dac, pos, neg);
        chk("R6 settle oe", oe, 1);
        chk("R6 settle low", d, 0);
        chk("R6 settle busy", bz, 1);
        chk("R6 settle dac", dac, 128);
        chk(sgl ? "R3 R4 pos single" : "R3 R5 pos diff", pos, ep);
        chk(sgl ? "R4 neg reference" : "R5 neg partner", neg, en);
        for (int j = 1; j <= 8; j++) begin
            if (noise) din = ~din;
            tick();
            get(v8, d, oe, bz, boe, dac, pos, neg);
            chk(noise ? "R10 R8 msb stream" : "R8 msb stream", d, (code >> (8 - j)) & 1);
            chk("R9 busy window", bz, (j < 8) ? 1 : 0);
        end
        chk("R7 final code", dac, code);
        chk("R4 selects off", pos | neg, 0);
        for (int h = 0; h < hold_n; h++) begin
            if (noise) din = ~din;
            tick();
            get(v8, d, oe, bz, boe, dac, pos, neg);
            chk("R12 lsb held", d, code & 1);
            chk("R12 held oe", oe, 1);
        end
        lsb_hold = 1'b0;
        for (int m = 1; m <= 7; m++) begin
            if (noise) din = ~din;
            tick();
            get(v8, d, oe, bz, boe, dac, pos, neg);
            chk(v8 ? "R12 lsb-first" : "R11 lsb-first", d, (code >> m) & 1);
        end
        tick();
        get(v8, d, oe, bz, boe, dac, pos, neg);
        chk("R13 released", oe, 0);
        din = 1'b1;
        tick(); tick(); tick();
        get(v8, d, oe, bz, boe, dac, pos, neg);
        chk("R13 no restart", oe | bz, 0);
        din = 1'b0;
        set_cs(v8, 1'b1);
        #1;
        check_idle(v8, "post");
    endtask

    task automatic abort8();
        int d, oe, bz, boe, dac, pos, neg;
        din = 1'b0; cs8_n = 1'b0;
        din = 1'b1; tick();
        din = 1'b1; tick(); din = 1'b0; tick(); tick(); tick();
        tick(); tick(); tick();
        get(1'b1, d, oe, bz, boe, dac, pos, neg);
        chk("R1 mid conversion busy", bz, 1);
        #(CLK_PERIOD/4);
        cs8_n = 1'b1;
        #1;
        check_idle(1'b1, "abort");
        get(1'b1, d, oe, bz, boe, dac, pos, neg);
        chk("R1 abort dac", dac, 0);
        tick();
    endtask

    initial begin
        cs8_n = 1'b1; cs4_n = 1'b1; din = 1'b0; lsb_hold = 1'b0;
        for (int i = 0; i < 9; i++) ain8[i] = 0;
        for (int i = 0; i < 5; i++) ain4[i] = 0;
        tick(); tick();
        check_idle(1'b1, "reset8");
        check_idle(1'b0, "reset4");

        for (int w = 0; w < 16; w++) begin
            for (int i = 0; i < 8; i++) ain8[i] = (i * 37 + w * 53 + 11) % 256;
            ain8[8] = (w * 19) % 90;
            conv(1'b1, w, w % 3, w[0]);
        end
        for (int w = 0; w < 8; w++) begin
            for (int i = 0; i < 4; i++) ain4[i] = (i * 71 + w * 29 + 5) % 256;
            ain4[4] = 0;
            conv(1'b0, w, 0, w[1]);
        end
        // comparator equal everywhere: code 0 (R7)
        for (int i = 0; i < 9; i++) ain8[i] = 100;
        conv(1'b1, 4'b1010, 1, 1'b0);
        // over-range and negative differences clamp (R7)
        ain8[0] = 300; ain8[1] = 0; ain8[8] = 0;
        conv(1'b1, 4'b0000, 0, 1'b0);
        conv(1'b1, 4'b0100, 0, 1'b0);
        ain4[2] = 255; ain4[3] = 254;
        conv(1'b0, 3'b101, 0, 1'b0);
        abort8();
        for (int i = 0; i < 9; i++) ain8[i] = 200 - i * 20;
        conv(1'b1, 4'b1001, 2, 1'b1);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule